// File: doc/BRIEF.md
# Configurable Leading/Trailing Zero Counter

This block is the zero-counting unit of a processor execution pipeline. It takes a 64-bit operand and returns how many zero bits come before the first set bit. One control input picks the scan direction. Leading zeros are counted downward from the most significant bit. Trailing zeros are counted upward from bit 0. A second control input picks the operand size: the whole 64-bit doubleword, or only the low 32-bit word.

The count is placed in a 64-bit result with zero extension and is held in a register. It appears on the output one clock after the operand and controls are presented. An operand with no set bit in the examined field returns the field width: 64 for a doubleword and 32 for a word. It never returns an undefined value.

Internally one priority encoder serves all four combinations. For a trailing count the examined field is bit-reversed. For a word-mode count a sentinel one is placed just below the low word. This caps the count at 32 and makes an all-zero word report 32.

Top module: `zero_count_unit`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `cnt_out` is 0.
- R2: `cnt_out` changes only on a rising clock edge. It shows the count for the operand and controls that were present at that edge, and it holds that value until the next edge.
- R3: With `cnt_trail`=0 and `word_mode`=0, an operand whose highest set bit is at position 63-i gives a count of i, for every i from 0 to 63.
- R4: With `cnt_trail`=1 and `word_mode`=0, an operand whose lowest set bit is at position i gives a count of i, for every i from 0 to 63.
- R5: With `word_mode`=0, an all-zero operand gives 64 (0x40) for both values of `cnt_trail`.
- R6: With `cnt_trail`=0 and `word_mode`=1, a low word whose highest set bit is at position 31-i gives i. Bits 63..32 of the operand have no effect.
- R7: With `cnt_trail`=1 and `word_mode`=1, a low word whose lowest set bit is at position i gives i. Bits 63..32 of the operand have no effect.
- R8: With `word_mode`=1, an all-zero low word gives 32 (0x20) for both directions, whatever bits 63..32 hold.
- R9: Bits 63..7 of `cnt_out` are always zero. In word mode the count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd | input | 64 | Operand to scan |
| cnt_trail | input | 1 | 0 = count leading zeros, 1 = count trailing zeros |
| word_mode | input | 1 | 0 = 64-bit doubleword, 1 = low 32-bit word only |
| cnt_out | output | 64 | Registered zero count, zero-extended |

## Verification
Two behaviours can fall on the same operand in one cycle: the size selection that discards bits 63..32, and the all-zero fallback to the field width. The bench provokes both together by driving word-mode operands with a zero low word and a busy upper half, in both directions. A correct result is 32, not 64 and not a count taken from the upper half. Every such operand, along with the single-bit sweeps with random lower-order noise, is queued with an expected value that an independent bit-scan model computes, and it is compared one edge later.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;
    typedef enum logic [1:0] {
        SCAN_DW_LEAD  = 2'b00,
        SCAN_DW_TRAIL = 2'b01,
        SCAN_W_LEAD   = 2'b10,
        SCAN_W_TRAIL  = 2'b11
    } scan_mode_e;

    function automatic scan_mode_e pick_mode(input logic word, input logic trail);
        return scan_mode_e'({word, trail});
    endfunction
endpackage

// File: rtl/zc_field_prep.sv
module zc_field_prep
    import zcnt_pkg::*;
#(
    parameter int DW = 64,
    localparam int HW = DW / 2
) (
    input  logic [DW-1:0] opnd,
    input  scan_mode_e    mode,
    output logic [DW-1:0] field
);
    logic [DW-1:0] rev_full;
    logic [HW-1:0] rev_low;
    logic [HW-1:0] sentinel;

    assign sentinel = {1'b1, {(HW-1){1'b0}}};

    for (genvar g = 0; g < DW; g++) begin : g_rev_full
        assign rev_full[g] = opnd[DW-1-g];
    end

    for (genvar g = 0; g < HW; g++) begin : g_rev_low
        assign rev_low[g] = opnd[HW-1-g];
    end

    always_comb begin
        unique case (mode)
            SCAN_DW_LEAD:  field = opnd;
            SCAN_DW_TRAIL: field = rev_full;
            SCAN_W_LEAD:   field = {opnd[HW-1:0], sentinel};
            SCAN_W_TRAIL:  field = {rev_low, sentinel};
            default:       field = opnd;
        endcase
    end
endmodule

// File: rtl/zc_prio_enc.sv
module zc_prio_enc #(
    parameter int DW = 64,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic [DW-1:0] field,
    output logic [CW-1:0] lead_cnt
);
    always_comb begin
        lead_cnt = CW'(DW);
        for (int i = 0; i < DW; i++) begin
            if (field[i]) begin
                lead_cnt = CW'(DW - 1 - i);
            end
        end
    end
endmodule

// File: rtl/zc_result_reg.sv
module zc_result_reg #(
    parameter int DW = 64,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_d,
    output logic [DW-1:0] cnt_q
);
    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_r <= '0;
        end else begin
            cnt_r <= cnt_d;
        end
    end

    assign cnt_q = {{(DW-CW){1'b0}}, cnt_r};
endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
    import zcnt_pkg::*;
#(
    parameter int DW = 64,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opnd,
    input  logic          cnt_trail,
    input  logic          word_mode,
    output logic [DW-1:0] cnt_out
);
    scan_mode_e    mode;
    logic [DW-1:0] field;
    logic [CW-1:0] cnt_comb;

    assign mode = pick_mode(word_mode, cnt_trail);

    zc_field_prep #(.DW(DW)) u_prep (
        .opnd  (opnd),
        .mode  (mode),
        .field (field)
    );

    zc_prio_enc #(.DW(DW)) u_enc (
        .field    (field),
        .lead_cnt (cnt_comb)
    );

    zc_result_reg #(.DW(DW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_d (cnt_comb),
        .cnt_q (cnt_out)
    );
endmodule

// File: rtl/zero_count_unit_chk.sv
module zero_count_unit_chk #(
    parameter int DW = 64,
    localparam int HW = DW / 2,
    localparam int CW = $clog2(DW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] opnd,
    input logic          cnt_trail,
    input logic          word_mode,
    input logic [DW-1:0] cnt_out
);
    // R9: upper result bits stay zero
    a_r9_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_out[DW-1:CW] == '0);

    // R9: word mode count bounded by word width
    a_r9_word_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |=> cnt_out <= DW'(HW));

    // R5: all-zero doubleword gives full width
    a_r5_dw_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode && opnd == '0) |=> cnt_out == DW'(DW));

    // R8: all-zero low word gives word width
    a_r8_w_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && opnd[HW-1:0] == '0) |=> cnt_out == DW'(HW));

    // R3: top bit set gives zero leading count
    a_r3_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_trail && !word_mode && opnd[DW-1]) |=> cnt_out == '0);

    // R4: bit 0 set gives zero trailing count
    a_r4_bit0_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_trail && opnd[0]) |=> cnt_out == '0);

    // R6: word-mode leading count of a set bit 31 is zero
    a_r6_word_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_trail && word_mode && opnd[HW-1]) |=> cnt_out == '0);
endmodule

bind zero_count_unit zero_count_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd      (opnd),
    .cnt_trail (cnt_trail),
    .word_mode (word_mode),
    .cnt_out   (cnt_out)
);

// File: tb/zero_count_unit_tb.sv
module zero_count_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd = 64'hDEAD_BEEF_1234_5678;
    logic        cnt_trail = 1'b0;
    logic        word_mode = 1'b0;
    logic [63:0] cnt_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    zero_count_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .opnd      (opnd),
        .cnt_trail (cnt_trail),
        .word_mode (word_mode),
        .cnt_out   (cnt_out)
    );

    function automatic logic [63:0] ref_count(input logic [63:0] op, input logic tr, input logic wm);
        int w = wm ? 32 : 64;
        int c = 0;
        if (tr) begin
            for (int k = 0; k < w; k++) begin
                if (op[k]) break;
                c++;
            end
        end else begin
            for (int k = w - 1; k >= 0; k--) begin
                if (op[k]) break;
                c++;
            end
        end
        return 64'(c);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] op, input logic tr, input logic wm, input string tag);
        item_t it;
        @(negedge clk);
        opnd = op;
        cnt_trail = tr;
        word_mode = wm;
        it.exp = ref_count(op, tr, wm);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: one item per rising edge, sampled 1 ns after it
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, cnt_out, it.exp);
            check("R9 upper bits", {57'd0, cnt_out[63:7]}, 64'd0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] noise;
        #7;
        check("R1 reset value", cnt_out, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 and R8 zero cases, with busy upper half in word mode
        apply(64'd0, 1'b0, 1'b0, "R5 lead zero dword");
        apply(64'd0, 1'b1, 1'b0, "R5 trail zero dword");
        apply(64'd0, 1'b0, 1'b1, "R8 lead zero word");
        apply(64'd0, 1'b1, 1'b1, "R8 trail zero word");
        apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, "R8 lead zero word upper busy");
        apply(64'h8000_0001_0000_0000, 1'b1, 1'b1, "R8 trail zero word upper busy");

        for (int i = 0; i < 64; i++) begin
            noise = {$urandom, $urandom};
            apply((64'd1 << (63 - i)) | (noise & ((64'd1 << (63 - i)) - 64'd1)), 1'b0, 1'b0, "R3 lead dword");
            noise = {$urandom, $urandom};
            apply((64'd1 << i) | (noise & ~((64'd2 << i) - 64'd1)), 1'b1, 1'b0, "R4 trail dword");
        end
        for (int i = 0; i < 32; i++) begin
            noise = {$urandom, $urandom};
            apply({noise[63:32], 32'd0} | (64'd1 << (31 - i)) | (noise & ((64'd1 << (31 - i)) - 64'd1) & 64'hFFFF_FFFF),
                  1'b0, 1'b1, "R6 lead word");
            noise = {$urandom, $urandom};
            apply({noise[63:32], 32'd0} | (64'd1 << i) | (noise & ~((64'd2 << i) - 64'd1) & 64'hFFFF_FFFF),
                  1'b1, 1'b1, "R7 trail word");
        end
        @(negedge clk);
        @(negedge clk);

        // R2: hold between edges
        apply(64'h0000_0000_0000_0100, 1'b1, 1'b0, "R2 new value after edge");
        @(negedge clk);
        opnd = 64'h0000_0000_0000_0001;
        #1;
        check("R2 held before edge", cnt_out, 64'd8);
        @(posedge clk);
        #1;
        check("R2 updated at edge", cnt_out, 64'd0);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        opnd = 64'd0;
        cnt_trail = 1'b0;
        word_mode = 1'b0;
        @(posedge clk);
        #1;
        check("R5 before reset", cnt_out, 64'd64);
        rst_n = 1'b0;
        #0.5;
        check("R1 async reset", cnt_out, 64'd0);
        @(posedge clk);
        #1;
        check("R1 reset held", cnt_out, 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule